// File: doc/BRIEF.md
# CAN Receive Mailbox Allocator

This block sits behind a CAN frame decoder and files every complete received frame into one of a small set of receive mailboxes. The decoder presents the frame for one cycle: identifier, format bit, remote-request bit, length code and eight data bytes. In that same cycle the block picks the mailbox that will hold the frame. Each mailbox has an identifier word and a local acceptance mask, both written through a configuration port. It also has four per-mailbox control bits supplied as vectors: enable, receive direction, overwrite protection and interrupt mask.

A frame goes to the highest-numbered mailbox that is enabled, set to receive, passes its identifier filter, and is not blocked by overwrite protection. Storing a frame raises that mailbox's pending flag. If the frame replaces an unread frame, the mailbox's lost flag is raised too. Both flag sets are cleared by writing ones. A combinational read port returns the stored identifier word, control word and two data words of any mailbox. Two interrupt outputs summarise the pending flags (after masking) and the lost flags.

Top module: `can_rx_mbox_alloc`

## Requirements
- R1: A frame on `rx_valid` is stored in the highest-numbered eligible mailbox. The frame is visible on the flags and the read port after the clock edge that samples it.
- R2: Identifier words use bit 31 for extended format, bit 30 for acceptance-mask enable and bit 29 for auto-answer. Bit 29 is held but has no effect here. The identifier field is bits 28:0. A standard 11-bit identifier sits at bits 28:18 with bits 17:0 zero, and an extended 29-bit identifier fills bits 28:0. The read port returns a stored frame's identifier in this layout, with bits 30 and 29 read as zero.
- R3: When bit 30 of a mailbox word is 1, each mask bit set to 1 excludes the matching identifier-field bit from comparison. When bit 30 is 0, every bit of the field must match exactly.
- R4: A frame whose format bit differs from bit 31 of a mailbox word is never accepted by that mailbox.
- R5: Storing a frame sets that mailbox's `rmp` bit. A 1 on `rmp_clr` clears that bit at the next edge, and an `rmp` bit changes in no other way.
- R6: A mailbox whose `mb_protect` bit and `rmp` bit are both set is skipped, and the search goes on to lower mailboxes. If no mailbox qualifies, the frame is dropped and no flag or stored frame changes.
- R7: Storing into a mailbox whose `rmp` bit is already set raises its `rml` bit. `rml_clr` clears `rml` bits by writing ones, and `lost_irq` is high exactly when some `rml` bit is set.
- R8: The read port gives the control word as length code in bits 3:0 and the remote-request bit in bit 4. The low data word holds bytes 0..3 with byte 0 in bits 31:24. The high data word holds bytes 4..7 with byte 4 in bits 31:24. On the input, byte 0 is `rx_data[63:56]`.
- R9: `mbx_irq` is high exactly when some mailbox has both its `rmp` bit and its `mb_int_mask` bit set.
- R10: After reset, `rmp` and `rml` are zero, both interrupt outputs are low, and all identifier words and masks are zero.
- R11: A mailbox with `mb_enable` low or `mb_is_rx` low never receives a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a decoded frame |
| rx_ide | input | 1 | Frame uses extended identifier |
| rx_rtr | input | 1 | Remote-request frame |
| rx_id | input | 29 | Identifier, right aligned (standard uses bits 10:0) |
| rx_dlc | input | 4 | Length code |
| rx_data | input | 64 | Data bytes, byte 0 in bits 63:56 |
| cfg_we | input | 1 | Write identifier word and mask of `cfg_sel` |
| cfg_sel | input | IDX_W | Mailbox being configured |
| cfg_id_word | input | 32 | Identifier word (R2 layout) |
| cfg_mask | input | 29 | Local acceptance mask, 1 = ignore bit |
| mb_enable | input | NUM_MBOX | Per-mailbox enable |
| mb_is_rx | input | NUM_MBOX | Per-mailbox receive direction |
| mb_protect | input | NUM_MBOX | Per-mailbox overwrite protection |
| mb_int_mask | input | NUM_MBOX | Per-mailbox interrupt enable |
| rmp_clr | input | NUM_MBOX | Write-one-to-clear for pending flags |
| rml_clr | input | NUM_MBOX | Write-one-to-clear for lost flags |
| rd_sel | input | IDX_W | Mailbox shown on the read port |
| rd_id_word | output | 32 | Stored identifier word |
| rd_ctrl | output | 32 | Stored control word |
| rd_data_lo | output | 32 | Stored bytes 0..3 |
| rd_data_hi | output | 32 | Stored bytes 4..7 |
| rmp | output | NUM_MBOX | Pending flags |
| rml | output | NUM_MBOX | Lost flags |
| mbx_irq | output | 1 | Masked pending summary |
| lost_irq | output | 1 | Lost summary |

## Verification
The bench builds the block with the default of eight mailboxes. With eight, one mailbox can be protected, disabled or turned to transmit while two others share its filter, so each fall-through step of the priority search gets exercised. Random filters and frames use an identifier space of only four values with random mask bits. This makes collisions between mailboxes, overwrites of unread frames and fully blocked drops frequent, rather than rare events in a 29-bit space.

// File: rtl/can_rx_pkg.sv
`timescale 1ns/1ps
package can_rx_pkg;
    localparam int ID_W      = 29;
    localparam int DLC_W     = 4;
    localparam int DATA_W    = 64;
    localparam int WORD_W    = 32;
    localparam int STD_W     = 11;
    localparam int STD_SHIFT = ID_W - STD_W;

    typedef struct packed {
        logic              ide;
        logic              rtr;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [DATA_W-1:0] data;
    } rx_frame_t;

    typedef struct packed {
        logic            ext;
        logic            mask_en;
        logic            auto_ans;
        logic [ID_W-1:0] id;
    } mbx_word_t;

    function automatic logic [ID_W-1:0] id_field(input logic ide, input logic [ID_W-1:0] id);
        return ide ? id : {id[STD_W-1:0], {STD_SHIFT{1'b0}}};
    endfunction

    function automatic logic filter_hit(input mbx_word_t f, input logic [ID_W-1:0] mask,
                                        input logic ide, input logic [ID_W-1:0] pos);
        logic [ID_W-1:0] care;
        care = f.mask_en ? ~mask : {ID_W{1'b1}};
        return (ide == f.ext) && (((pos ^ f.id) & care) == '0);
    endfunction
endpackage

// File: rtl/can_rx_filter.sv
`timescale 1ns/1ps
module can_rx_filter
    import can_rx_pkg::*;
#(
    parameter int NUM_MBOX = 8,
    localparam int IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_sel,
    input  logic [WORD_W-1:0]   cfg_id_word,
    input  logic [ID_W-1:0]     cfg_mask,
    input  logic                rx_ide,
    input  logic [ID_W-1:0]     rx_pos,
    output logic [NUM_MBOX-1:0] hit
);
    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbx
        mbx_word_t       word_q;
        logic [ID_W-1:0] mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                word_q <= '0;
                mask_q <= '0;
            end else if (cfg_we && (cfg_sel == IDX_W'(i))) begin
                word_q <= mbx_word_t'(cfg_id_word);
                mask_q <= cfg_mask;
            end
        end

        assign hit[i] = filter_hit(word_q, mask_q, rx_ide, rx_pos);
    end
endmodule

// File: rtl/can_rx_select.sv
`timescale 1ns/1ps
module can_rx_select #(
    parameter int NUM_MBOX = 8,
    localparam int IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic [NUM_MBOX-1:0] hit,
    input  logic [NUM_MBOX-1:0] enable,
    input  logic [NUM_MBOX-1:0] is_rx,
    input  logic [NUM_MBOX-1:0] protect,
    input  logic [NUM_MBOX-1:0] pending,
    output logic [NUM_MBOX-1:0] grant,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);
    logic [NUM_MBOX-1:0] eligible;

    assign eligible = hit & enable & is_rx & ~(protect & pending);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NUM_MBOX; i++) begin
            if (eligible[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
        grant = '0;
        if (found) grant[idx] = 1'b1;
    end
endmodule

// File: rtl/can_rx_store.sv
`timescale 1ns/1ps
module can_rx_store
    import can_rx_pkg::*;
#(
    parameter int NUM_MBOX = 8,
    localparam int IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  rx_frame_t           frame,
    input  logic [NUM_MBOX-1:0] rmp_clr,
    input  logic [NUM_MBOX-1:0] rml_clr,
    input  logic [IDX_W-1:0]    rd_sel,
    output logic [WORD_W-1:0]   rd_id_word,
    output logic [WORD_W-1:0]   rd_ctrl,
    output logic [WORD_W-1:0]   rd_data_lo,
    output logic [WORD_W-1:0]   rd_data_hi,
    output logic [NUM_MBOX-1:0] rmp,
    output logic [NUM_MBOX-1:0] rml
);
    rx_frame_t           slot_q [NUM_MBOX];
    logic [NUM_MBOX-1:0] rmp_q, rml_q;
    rx_frame_t           rd_f;

    always_ff @(posedge clk) begin
        if (we) slot_q[idx] <= frame;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rmp_q <= '0;
            rml_q <= '0;
        end else begin
            rmp_q <= (rmp_q & ~rmp_clr) | (we ? (NUM_MBOX'(1) << idx) : '0);
            rml_q <= (rml_q & ~rml_clr) |
                     ((we && rmp_q[idx]) ? (NUM_MBOX'(1) << idx) : '0);
        end
    end

    assign rd_f       = slot_q[rd_sel];
    assign rd_id_word = {rd_f.ide, 2'b00, id_field(rd_f.ide, rd_f.id)};
    assign rd_ctrl    = {{(WORD_W-DLC_W-1){1'b0}}, rd_f.rtr, rd_f.dlc};
    assign rd_data_lo = rd_f.data[DATA_W-1 -: WORD_W];
    assign rd_data_hi = rd_f.data[WORD_W-1:0];
    assign rmp        = rmp_q;
    assign rml        = rml_q;
endmodule

// File: rtl/can_rx_mbox_alloc.sv
`timescale 1ns/1ps
module can_rx_mbox_alloc
    import can_rx_pkg::*;
#(
    parameter int NUM_MBOX = 8,
    localparam int IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_valid,
    input  logic                rx_ide,
    input  logic                rx_rtr,
    input  logic [28:0]         rx_id,
    input  logic [3:0]          rx_dlc,
    input  logic [63:0]         rx_data,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_sel,
    input  logic [31:0]         cfg_id_word,
    input  logic [28:0]         cfg_mask,
    input  logic [NUM_MBOX-1:0] mb_enable,
    input  logic [NUM_MBOX-1:0] mb_is_rx,
    input  logic [NUM_MBOX-1:0] mb_protect,
    input  logic [NUM_MBOX-1:0] mb_int_mask,
    input  logic [NUM_MBOX-1:0] rmp_clr,
    input  logic [NUM_MBOX-1:0] rml_clr,
    input  logic [IDX_W-1:0]    rd_sel,
    output logic [31:0]         rd_id_word,
    output logic [31:0]         rd_ctrl,
    output logic [31:0]         rd_data_lo,
    output logic [31:0]         rd_data_hi,
    output logic [NUM_MBOX-1:0] rmp,
    output logic [NUM_MBOX-1:0] rml,
    output logic                mbx_irq,
    output logic                lost_irq
);
    logic [NUM_MBOX-1:0] hit, grant;
    logic                found, store_we;
    logic [IDX_W-1:0]    store_idx;
    rx_frame_t           frame;

    assign frame = '{ide: rx_ide, rtr: rx_rtr, id: rx_id, dlc: rx_dlc, data: rx_data};

    can_rx_filter #(.NUM_MBOX(NUM_MBOX)) u_filter (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_id_word(cfg_id_word), .cfg_mask(cfg_mask),
        .rx_ide(rx_ide), .rx_pos(id_field(rx_ide, rx_id)), .hit(hit)
    );

    can_rx_select #(.NUM_MBOX(NUM_MBOX)) u_select (
        .hit(hit), .enable(mb_enable), .is_rx(mb_is_rx), .protect(mb_protect),
        .pending(rmp), .grant(grant), .found(found), .idx(store_idx)
    );

    assign store_we = rx_valid && found;

    can_rx_store #(.NUM_MBOX(NUM_MBOX)) u_store (
        .clk(clk), .rst(rst), .we(store_we), .idx(store_idx), .frame(frame),
        .rmp_clr(rmp_clr), .rml_clr(rml_clr), .rd_sel(rd_sel),
        .rd_id_word(rd_id_word), .rd_ctrl(rd_ctrl),
        .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi),
        .rmp(rmp), .rml(rml)
    );

    assign mbx_irq  = |(rmp & mb_int_mask);
    assign lost_irq = |rml;
endmodule

// File: rtl/can_rx_mbox_alloc_chk.sv
`timescale 1ns/1ps
module can_rx_mbox_alloc_chk #(
    parameter int NUM_MBOX = 8,
    localparam int IDX_W = (NUM_MBOX > 1) ? $clog2(NUM_MBOX) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_MBOX-1:0] mb_enable,
    input logic [NUM_MBOX-1:0] mb_is_rx,
    input logic [NUM_MBOX-1:0] mb_protect,
    input logic [NUM_MBOX-1:0] rmp_clr,
    input logic [NUM_MBOX-1:0] rmp,
    input logic [NUM_MBOX-1:0] rml,
    input logic                mbx_irq,
    input logic                lost_irq,
    input logic [NUM_MBOX-1:0] grant,
    input logic                store_we,
    input logic [IDX_W-1:0]    store_idx
);
    a_r1_single_target: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));

    a_r11_target_open: assert property (@(posedge clk) disable iff (rst)
        store_we |-> (mb_enable[store_idx] && mb_is_rx[store_idx]));

    a_r9_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        mbx_irq |-> (rmp != '0));

    a_r7_lost_irq_source: assert property (@(posedge clk) disable iff (rst)
        lost_irq |-> (rml != '0));

    for (genvar i = 0; i < NUM_MBOX; i++) begin : g_mbx
        a_r5_set_by_store: assert property (@(posedge clk) disable iff (rst)
            $rose(rmp[i]) |-> ($past(store_we) && $past(store_idx) == IDX_W'(i)));
        a_r5_clear_by_host: assert property (@(posedge clk) disable iff (rst)
            $fell(rmp[i]) |-> $past(rmp_clr[i]));
        a_r6_protected_skip: assert property (@(posedge clk) disable iff (rst)
            (store_we && rmp[i] && mb_protect[i]) |-> (store_idx != IDX_W'(i)));
        a_r7_lost_after_pending: assert property (@(posedge clk) disable iff (rst)
            $rose(rml[i]) |-> $past(rmp[i]));
    end
endmodule

bind can_rx_mbox_alloc can_rx_mbox_alloc_chk #(.NUM_MBOX(NUM_MBOX)) u_chk (
    .clk(clk), .rst(rst), .mb_enable(mb_enable), .mb_is_rx(mb_is_rx),
    .mb_protect(mb_protect), .rmp_clr(rmp_clr), .rmp(rmp), .rml(rml),
    .mbx_irq(mbx_irq), .lost_irq(lost_irq), .grant(grant),
    .store_we(store_we), .store_idx(store_idx)
);

// File: tb/can_rx_mbox_alloc_tb.sv
`timescale 1ns/1ps
module can_rx_mbox_alloc_tb;
    localparam int N = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_valid = 0, rx_ide = 0, rx_rtr = 0;
    logic [28:0] rx_id = '0;
    logic [3:0]  rx_dlc = '0;
    logic [63:0] rx_data = '0;
    logic cfg_we = 0;
    logic [IW-1:0] cfg_sel = '0;
    logic [31:0] cfg_id_word = '0;
    logic [28:0] cfg_mask = '0;
    logic [N-1:0] mb_enable = '0, mb_is_rx = '0, mb_protect = '0, mb_int_mask = '0;
    logic [N-1:0] rmp_clr = '0, rml_clr = '0;
    logic [IW-1:0] rd_sel = '0;
    logic [31:0] rd_id_word, rd_ctrl, rd_data_lo, rd_data_hi;
    logic [N-1:0] rmp, rml;
    logic mbx_irq, lost_irq;

    always #2 clk = ~clk;

    can_rx_mbox_alloc #(.NUM_MBOX(N)) u_dut (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
        .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_id_word(cfg_id_word), .cfg_mask(cfg_mask),
        .mb_enable(mb_enable), .mb_is_rx(mb_is_rx), .mb_protect(mb_protect),
        .mb_int_mask(mb_int_mask), .rmp_clr(rmp_clr), .rml_clr(rml_clr),
        .rd_sel(rd_sel), .rd_id_word(rd_id_word), .rd_ctrl(rd_ctrl),
        .rd_data_lo(rd_data_lo), .rd_data_hi(rd_data_hi), .rmp(rmp), .rml(rml),
        .mbx_irq(mbx_irq), .lost_irq(lost_irq)
    );

    int n_checks = 0;
    int n_fail = 0;

    logic [31:0] m_word [N];
    logic [28:0] m_mask [N];
    logic        s_ide [N];
    logic        s_rtr [N];
    logic [28:0] s_id  [N];
    logic [3:0]  s_dlc [N];
    logic [63:0] s_data[N];
    logic [N-1:0] m_rmp = '0, m_rml = '0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [28:0] pos_of(input logic ide, input logic [28:0] id);
        return ide ? id : {id[10:0], 18'b0};
    endfunction

    function automatic int predict(input logic ide, input logic [28:0] id);
        logic [28:0] p, care;
        p = pos_of(ide, id);
        for (int i = N - 1; i >= 0; i--) begin
            care = m_word[i][30] ? ~m_mask[i] : '1;
            if (mb_enable[i] && mb_is_rx[i] && !(mb_protect[i] && m_rmp[i]) &&
                (m_word[i][31] == ide) && (((p ^ m_word[i][28:0]) & care) == '0))
                return i;
        end
        return -1;
    endfunction

    task automatic check_flags(input string tag);
        check(rmp == m_rmp, {tag, " rmp (R5)"}, rmp, m_rmp);
        check(rml == m_rml, {tag, " rml (R7)"}, rml, m_rml);
        check(mbx_irq == |(m_rmp & mb_int_mask), {tag, " mbx_irq (R9)"}, mbx_irq, |(m_rmp & mb_int_mask));
        check(lost_irq == |m_rml, {tag, " lost_irq (R7)"}, lost_irq, |m_rml);
    endtask

    task automatic readback(input int i, input string tag);
        logic [31:0] e_id;
        rd_sel = IW'(i);
        #0.3;
        e_id = {s_ide[i], 2'b00, pos_of(s_ide[i], s_id[i])};
        check(rd_id_word == e_id, {tag, " id word (R2)"}, rd_id_word, e_id);
        check(rd_ctrl == {27'b0, s_rtr[i], s_dlc[i]}, {tag, " ctrl (R8)"}, rd_ctrl, {27'b0, s_rtr[i], s_dlc[i]});
        check(rd_data_lo == s_data[i][63:32], {tag, " data lo (R8)"}, rd_data_lo, s_data[i][63:32]);
        check(rd_data_hi == s_data[i][31:0], {tag, " data hi (R8)"}, rd_data_hi, s_data[i][31:0]);
    endtask

    task automatic configure(input int i, input logic [31:0] w, input logic [28:0] m);
        @(negedge clk);
        cfg_we = 1; cfg_sel = IW'(i); cfg_id_word = w; cfg_mask = m;
        @(posedge clk); #0.5;
        cfg_we = 0;
        m_word[i] = w; m_mask[i] = m;
    endtask

    task automatic send(input logic ide, input logic rtr, input logic [28:0] id,
                        input logic [3:0] dlc, input logic [63:0] data,
                        input int exp_tgt, input string tag);
        int t;
        t = predict(ide, id);
        if (exp_tgt != -2)
            check(t == exp_tgt, {tag, " bench target"}, t, exp_tgt);
        @(negedge clk);
        rx_valid = 1; rx_ide = ide; rx_rtr = rtr; rx_id = id; rx_dlc = dlc; rx_data = data;
        @(posedge clk); #0.5;
        rx_valid = 0;
        if (t >= 0) begin
            if (m_rmp[t]) m_rml[t] = 1'b1;
            m_rmp[t] = 1'b1;
            s_ide[t] = ide; s_rtr[t] = rtr; s_id[t] = id; s_dlc[t] = dlc; s_data[t] = data;
        end
        check_flags(tag);
        if (t >= 0) readback(t, tag);
    endtask

    task automatic clear(input logic [N-1:0] pc, input logic [N-1:0] lc, input string tag);
        @(negedge clk);
        rmp_clr = pc; rml_clr = lc;
        @(posedge clk); #0.5;
        rmp_clr = '0; rml_clr = '0;
        m_rmp &= ~pc; m_rml &= ~lc;
        check_flags(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_word[i] = '0; m_mask[i] = '0;
            s_ide[i] = 0; s_rtr[i] = 0; s_id[i] = '0; s_dlc[i] = '0; s_data[i] = '0;
        end
        repeat (3) @(posedge clk);
        #0.5 rst = 0;
        check_flags("R10 reset");
        check(rmp == '0 && !mbx_irq && !lost_irq, "R10 reset outputs", {rmp, mbx_irq, lost_irq}, 0);

        // directed set-up: std ids 0x100+i, 7 and 5 share 0x123, 3 is extended 0x123, 6 masked
        for (int i = 0; i < N; i++) configure(i, {3'b000, (11'h100 + 11'(i)), 18'b0}, '0);
        configure(7, {3'b000, 11'h123, 18'b0}, '0);
        configure(5, {3'b001, 11'h123, 18'b0}, '0);
        configure(3, {3'b100, 29'h123}, '0);
        configure(6, {3'b010, 11'h200, 18'b0}, {7'b0, 4'hF, 18'b0});
        mb_enable = '1; mb_is_rx = '1; mb_int_mask = '1;

        send(0, 0, 29'h123, 4'd8, 64'h0011223344556677, 7, "R1 highest match");
        check(rmp == 8'h80, "R1 pending at mailbox 7", rmp, 8'h80);
        send(0, 1, 29'h123, 4'd2, 64'hA1B2C3D4E5F60718, 7, "R7 overwrite");
        check(rml == 8'h80, "R7 lost at mailbox 7", rml, 8'h80);
        mb_protect[7] = 1;
        send(0, 0, 29'h123, 4'd5, 64'h1122334455667788, 5, "R6 skip protected");
        mb_protect[5] = 1;
        send(0, 0, 29'h123, 4'd1, 64'hFFFF0000FFFF0000, -1, "R6 all blocked drop");
        readback(7, "R6 mailbox 7 kept");
        readback(5, "R6 mailbox 5 kept");
        clear(8'hA0, 8'h00, "R5 clear pending");
        send(1, 0, 29'h123, 4'd3, 64'h0102030405060708, 3, "R4 extended only");
        send(0, 0, 29'h20A, 4'd4, 64'h8877665544332211, 6, "R3 masked accept");
        send(0, 0, 29'h21A, 4'd4, 64'h0, -1, "R3 unmasked bit rejects");
        mb_protect = '0;
        mb_enable[7] = 0;
        send(0, 0, 29'h123, 4'd6, 64'hCAFEBABE12345678, 5, "R11 disabled skipped");
        mb_is_rx[5] = 0;
        send(0, 0, 29'h123, 4'd6, 64'h0, -1, "R11 transmit skipped");
        mb_int_mask = '0;
        #0.5 check(mbx_irq == 1'b0 && rmp != '0, "R9 masked irq low", mbx_irq, 0);
        mb_int_mask = 8'h40;
        #0.5 check(mbx_irq == 1'b1, "R9 unmasked irq high", mbx_irq, 1);
        clear(8'h00, 8'hFF, "R7 clear lost");
        clear(8'hFF, 8'h00, "R5 clear all");

        // random phase
        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < N; i++) begin
                logic ide;
                ide = 1'($urandom);
                configure(i, {ide, 1'($urandom), 1'($urandom), pos_of(ide, 29'($urandom % 4))},
                          29'($urandom) & {29{1'($urandom)}});
            end
            mb_enable = N'($urandom) | N'($urandom);
            mb_is_rx = N'($urandom) | N'($urandom);
            mb_protect = N'($urandom);
            mb_int_mask = N'($urandom);
            for (int k = 0; k < 50; k++) begin
                send(1'($urandom), 1'($urandom), 29'($urandom % 4), 4'($urandom),
                     {$urandom, $urandom}, -2, "R1 random");
                if (k % 5 == 4) clear(N'($urandom), N'($urandom), "R5 random clear");
            end
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule